// File: doc/BRIEF.md
# DMA Interrupt Status and Summary Register

This block keeps the interrupt state of a DMA engine. Single-cycle event pulses from the transmit path, the receive path and the bus interface are caught in sticky status bits, and software clears each bit by writing 1 to it. A separate enable register selects which sources take part in the abnormal-interrupt summary. That summary drives an interrupt line.

A fatal bus error records a 3-bit error code. It also withdraws the bus-access enable of the DMA engine until software clears the error. The early-receive flag clears itself once the receive-complete event arrives.

Software reaches the block through a simple word-addressed port with two registers, status and enable. Reads are combinational from the register state, and writes take effect at the clock edge.

Top module: `dmaIrqRegs`

## Requirements
- R1: An event pulse on `evtIn[i]`, for a live bit i (0 to 10, 13 or 14), sets status bit i at the next clock edge, whatever the enable register holds. The bit then stays set until it is cleared.
- R2: A write to address 0 clears every live status bit whose data bit is 1. Data bits of 0 leave their status bits unchanged.
- R3: If an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R4: Status bit 15 (summary) is the OR of status bits 1, 3, 4, 5, 7, 8, 9, 10 and 13, each ANDed with the same bit of the enable register. Status bits 0, 2, 6 and 14 and all disabled sources leave it at 0. It falls as soon as the enabled sources behind it have been cleared.
- R5: `irqOut` equals the summary bit as it was one cycle earlier.
- R6: Status bit 14 (early receive) is set by `evtIn[14]`. It is cleared by writing 1 to it, or by a pulse on `evtIn[6]` (receive complete). That pulse wins even against an early-receive event in the same cycle.
- R7: When status bit 13 (fatal bus error) goes from clear to set, `busErrCode` is captured into status bits 25:23. The code holds while the bit stays set, so later errors do not overwrite it. It returns to 0 when the bit is cleared. An error that arrives in the same cycle as the clear captures its new code.
- R8: `busEnable` is 0 exactly while status bit 13 is set.
- R9: Status bits 12:11, 22:16 and 31:26 read as 0. Writes to them, and a write of 1 to bit 15, have no effect.
- R10: Address 1 is a plain 32-bit read/write enable register. Any other address reads 0 and ignores writes.
- R11: After reset every status bit, the error code, the enable register and `irqOut` are 0, and `busEnable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe of the register port |
| regAddr | input | 2 | Word address (0 status, 1 enable) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the addressed register |
| evtIn | input | 15 | Event pulses, bit i sets status bit i |
| busErrCode | input | 3 | Error code sampled with a fatal bus error |
| irqOut | output | 1 | Registered abnormal-interrupt summary |
| busEnable | output | 1 | DMA bus-access permission |

## Verification
An event or a write changes the status word at the clock edge on which it is presented. The summary bit, the error code and `busEnable` follow in that same cycle, while `irqOut` trails by one more edge. The bench applies stimulus just after a falling edge. Its reference model advances at the rising edge, and it compares the read data, `irqOut` and `busEnable` at the next falling edge. Every cycle is therefore checked at the point where all results due from the previous edge have settled.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  typedef struct packed {
    logic statusW1c;
    logic maskWr;
    logic rdStatus;
    logic rdMask;
  } regStrobe_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int STATUS_ADDR = 0,
  parameter int MASK_ADDR   = 1
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] MaskA = ADDR_W'(MASK_ADDR);

  always_comb begin
    strb.rdStatus  = (regAddr == StatA);
    strb.rdMask    = (regAddr == MaskA);
    strb.statusW1c = regWrEn && strb.rdStatus;
    strb.maskWr    = regWrEn && strb.rdMask;
  end
endmodule

// File: rtl/dma_irq_data.sv
module dma_irq_data
  import dma_irq_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter int               EVT_W       = 15,
  parameter int               CODE_W      = 3,
  parameter int               CODE_LSB    = 23,
  parameter int               SUMMARY_BIT = 15,
  parameter int               ERI_BIT     = 14,
  parameter int               FBE_BIT     = 13,
  parameter int               RCV_BIT     = 6,
  parameter logic [EVT_W-1:0] LIVE_BITS   = 15'h67FF,
  parameter logic [EVT_W-1:0] ABN_BITS    = 15'h27BA
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic [CODE_W-1:0] errCode,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              busEnable
);
  localparam logic [EVT_W-1:0] NonEri = LIVE_BITS & ~(EVT_W'(1) << ERI_BIT);

  logic [EVT_W-1:0]  statQ, statD, clrVec;
  logic [CODE_W-1:0] codeQ;
  logic [DATA_W-1:0] maskQ, statusWord;
  logic              summary, irqQ;

  assign clrVec = strb.statusW1c ? wrData[EVT_W-1:0] : '0;

  // per-bit next state: set dominates a simultaneous write-1 clear
  for (genvar g = 0; g < EVT_W; g++) begin : gBit
    if (!LIVE_BITS[g]) begin : gRsvd
      assign statD[g] = 1'b0;
    end else if (g == ERI_BIT) begin : gEri
      assign statD[g] = !evtIn[RCV_BIT] && (evtIn[g] || (statQ[g] && !clrVec[g]));
    end else begin : gEvt
      assign statD[g] = evtIn[g] || (statQ[g] && !clrVec[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
      codeQ <= '0;
      maskQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      statQ <= statD;
      irqQ  <= summary;
      if (strb.maskWr) maskQ <= wrData;
      if (evtIn[FBE_BIT] && (!statQ[FBE_BIT] || clrVec[FBE_BIT]))
        codeQ <= errCode;
      else if (statQ[FBE_BIT] && clrVec[FBE_BIT])
        codeQ <= '0;
    end
  end

  assign summary   = |(statQ & maskQ[EVT_W-1:0] & ABN_BITS);
  assign irqOut    = irqQ;
  assign busEnable = !statQ[FBE_BIT];

  always_comb begin
    statusWord                       = '0;
    statusWord[EVT_W-1:0]            = statQ;
    statusWord[SUMMARY_BIT]          = summary;
    statusWord[CODE_LSB +: CODE_W]   = codeQ;
  end

  assign rdData = strb.rdStatus ? statusWord : (strb.rdMask ? maskQ : '0);

  // R1: any live non-early-receive event is visible after the edge
  p_event_latch_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((evtIn & NonEri) != '0) |=> ((statQ & $past(evtIn & NonEri)) == $past(evtIn & NonEri)));
  // R2: a write of 1 without a concurrent event clears the bit
  p_w1c_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec[1] && !evtIn[1]) |=> !statQ[1]);
  // R3: set beats clear
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec[3] && evtIn[3]) |=> statQ[3]);
  // R5: interrupt line trails the summary by one cycle
  p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    summary |=> irqOut);
  // R6: receive complete removes early receive
  p_rcv_clears_eri_r6: assert property (@(posedge clk) disable iff (!rstN)
    evtIn[RCV_BIT] |=> !statQ[ERI_BIT]);
  // R7: code held while the fatal bit stays set
  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[FBE_BIT] && !clrVec[FBE_BIT]) |=> $stable(codeQ));
endmodule

// File: rtl/dmaIrqRegs.sv
module dmaIrqRegs
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int EVT_W  = 15,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic [CODE_W-1:0] busErrCode,
  output logic              irqOut,
  output logic              busEnable
);
  regStrobe_t strb;

  dma_irq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  dma_irq_data #(.DATA_W(DATA_W), .EVT_W(EVT_W), .CODE_W(CODE_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (regWrData),
    .evtIn     (evtIn),
    .errCode   (busErrCode),
    .rdData    (regRdData),
    .irqOut    (irqOut),
    .busEnable (busEnable)
  );
endmodule

// File: tb/dmaIrqRegs_test.sv
module dmaIrqRegs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [14:0] evtIn = '0;
  logic [2:0]  busErrCode = '0;
  logic        irqOut, busEnable;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  logic [14:0] mStat = '0;
  logic [2:0]  mCode = '0;
  logic [31:0] mMask = '0;
  logic        mIrq = 1'b0;

  always #2 clk = ~clk;

  dmaIrqRegs uut (.*);

  function automatic logic mSum();
    return |(mStat & mMask[14:0] & 15'h27BA);
  endfunction

  function automatic logic [31:0] mRead(input logic [1:0] a);
    logic [31:0] w = '0;
    if (a == 2'd0) begin
      w[14:0]  = mStat;
      w[15]    = mSum();
      w[25:23] = mCode;
    end else if (a == 2'd1) begin
      w = mMask;
    end
    return w;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: model follows the requirements, then compare at the falling edge
  task automatic tick(input string tag);
    logic [14:0] clr, nS;
    logic [2:0]  nC;
    logic [31:0] nM;
    logic        nI;
    clr = (regWrEn && regAddr == 2'd0) ? regWrData[14:0] : '0;
    nS = '0;
    for (int i = 0; i < 15; i++) begin
      if (i == 11 || i == 12) continue;
      nS[i] = evtIn[i] | (mStat[i] & ~clr[i]);
    end
    if (evtIn[6]) nS[14] = 1'b0;
    nC = mCode;
    if (evtIn[13] && (!mStat[13] || clr[13])) nC = busErrCode;
    else if (mStat[13] && clr[13]) nC = '0;
    nM = (regWrEn && regAddr == 2'd1) ? regWrData : mMask;
    nI = mSum();
    @(posedge clk);
    if (!rstN) begin
      mStat = '0; mCode = '0; mMask = '0; mIrq = 1'b0;
    end else begin
      mStat = nS; mCode = nC; mMask = nM; mIrq = nI;
    end
    @(negedge clk);
    check(tag, "rdData", regRdData, mRead(regAddr));
    check(tag, "irqOut", {31'd0, irqOut}, {31'd0, mIrq});
    check(tag, "busEnable", {31'd0, busEnable}, {31'd0, !mStat[13]});
    regWrEn = 1'b0;
    regWrData = '0;
    evtIn = '0;
  endtask

  task automatic pulse(input int bitIdx, input string tag);
    evtIn[bitIdx] = 1'b1;
    tick(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(tag);
    regAddr = 2'd0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick("R11"); tick("R11");
    rstN = 1'b1;
    tick("R11");
    regAddr = 2'd1; tick("R11"); regAddr = 2'd0;

    pulse(2, "R1"); tick("R1");           // bit 2 sticky
    pulse(4, "R1"); tick("R4");           // disabled source: no summary
    wr(2'd1, 32'h0000_27BA, "R10");
    regAddr = 2'd1; tick("R10"); regAddr = 2'd0;
    tick("R4"); tick("R5");               // bit 4 now enabled
    wr(2'd0, 32'h0000_0000, "R2");        // write 0: nothing changes
    wr(2'd0, 32'h0000_8000, "R9");        // write 1 to summary
    wr(2'd0, 32'h0000_0010, "R2");        // clear bit 4, summary falls
    tick("R5");
    wr(2'd1, 32'hFFFF_FFFF, "R10");
    pulse(0, "R4"); pulse(6, "R4"); tick("R4"); // non-abnormal bits
    evtIn[5] = 1'b1; wr(2'd0, 32'h0000_0020, "R3");
    tick("R3");
    pulse(14, "R6"); pulse(6, "R6");
    pulse(14, "R6"); wr(2'd0, 32'h0000_4000, "R6");
    evtIn[14] = 1'b1; evtIn[6] = 1'b1; tick("R6");
    busErrCode = 3'd5; pulse(13, "R7"); tick("R8");
    busErrCode = 3'd2; pulse(13, "R7"); tick("R7");
    wr(2'd0, 32'h0000_2000, "R7"); tick("R8");
    busErrCode = 3'd6; pulse(13, "R7");
    evtIn[13] = 1'b1; busErrCode = 3'd3; wr(2'd0, 32'h0000_2000, "R7");
    wr(2'd0, 32'h0000_2000, "R8");
    wr(2'd0, 32'hFC7F_1800, "R9");
    wr(2'd2, 32'hFFFF_FFFF, "R10");
    regAddr = 2'd2; tick("R10"); regAddr = 2'd3; tick("R10"); regAddr = 2'd0;
    wr(2'd0, 32'hFFFF_FFFF, "R2");

    for (int n = 0; n < 400; n++) begin
      evtIn = 15'($urandom) & 15'($urandom);
      busErrCode = 3'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        regWrEn = 1'b1;
        regAddr = 2'($urandom_range(0, 2));
        regWrData = $urandom;
      end else begin
        regAddr = 2'($urandom_range(0, 1));
      end
      tick("R1");
    end
    regAddr = 2'd0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule